// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block drives the clock line of an I2C master. It holds two pairs of period counts, one pair for standard-speed operation and one for fast-speed operation. A speed select input chooses the pair, and the chosen values are frozen when a transfer starts. A start request opens a START hold interval with SCL released. After that the generator alternates between a low phase, in which it pulls SCL low, and a high phase, in which it releases SCL. Each phase adds a fixed overhead in clock cycles to its programmed count.

Counting in the high phase pauses whenever the sampled line reads low. This lets a target stretch the clock. When enable drops, the block completes the low phase it is in or next reaches, releases SCL and returns to idle. Two status outputs are provided. One reports that the generator is running. The other reports any activity on the bus, including a line held low by another device. Data shifting, acknowledge handling, arbitration and register access belong to neighbouring logic.

Top module: `scl_period_gen`

## Requirements
- R1: `speed_sel` = 0 selects the pair `std_hcnt`/`std_lcnt` and `speed_sel` = 1 selects the pair `fast_hcnt`/`fast_lcnt`. The value of `speed_sel` is taken in the cycle in which the start request is accepted.
- R2: A low phase (`phase_low` = 1, `scl_pull_low` = 1) lasts L+1 clock cycles, where L is the effective low count.
- R3: With no stretching, a high phase (`phase_high` = 1, `scl_pull_low` = 0) lasts H+8 clock cycles, where H is the effective high count.
- R4: A start request is accepted only while `en` = 1 and the block is idle. It begins a hold interval (`phase_hold` = 1, SCL released) of H+3 cycles, which is followed directly by the first low phase.
- R5: An effective high count is max(programmed, 6). An effective low count is max(programmed, 8).
- R6: Every high-phase cycle in which `scl_in` is sampled low adds one cycle to that high phase.
- R7: With `en` = 0, the generator finishes the low phase it is in or next enters, then goes idle with SCL released. While `en` = 1, a low phase is always followed by a high phase.
- R8: `mst_active` is 1 exactly while one of the three phase flags is 1. At most one phase flag is 1 at any time.
- R9: `bus_active` is 1 while the generator is running or while `scl_in` was sampled low in the previous cycle.
- R10: Changes to the count inputs or to `speed_sel` after a start has been accepted have no effect until the next start.
- R11: A start request while `en` = 0 is ignored.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| speed_sel | input | 1 | 0 = standard pair, 1 = fast pair |
| std_hcnt | input | CNT_W | Standard-speed high count |
| std_lcnt | input | CNT_W | Standard-speed low count |
| fast_hcnt | input | CNT_W | Fast-speed high count |
| fast_lcnt | input | CNT_W | Fast-speed low count |
| start_req | input | 1 | Request to begin a transfer clock |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull_low | output | 1 | 1 = drive SCL low |
| phase_hold | output | 1 | START hold interval in progress |
| phase_low | output | 1 | Low phase in progress |
| phase_high | output | 1 | High phase in progress |
| mst_active | output | 1 | Generator not idle |
| bus_active | output | 1 | Generator running or line seen low |

## Verification
On every cycle, the assertions check the following. The phase flags are mutually exclusive and agree with the activity flags. The hold interval is always followed by a low phase. A low phase is followed by either a high phase or idle. A stretched high phase cannot end. A disabled idle generator stays idle. Each completed phase is at least as long as the clamped minimum allows. Only the bench's sweeps can show that each phase has the exact length for a given count and speed, that counts are frozen at the start, and that a stretch extends the high phase by exactly the number of low samples.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // fixed cycle overheads added to programmed counts
  localparam int HOLD_OVH = 3;
  localparam int LOW_OVH  = 1;
  localparam int HIGH_OVH = 8;
endpackage

// File: rtl/scl_cnt_sel.sv
module scl_cnt_sel #(
  parameter int CNT_W = 16,
  parameter int H_MIN = 6,
  parameter int L_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             speed_sel,
  input  logic [CNT_W-1:0] std_hcnt,
  input  logic [CNT_W-1:0] std_lcnt,
  input  logic [CNT_W-1:0] fast_hcnt,
  input  logic [CNT_W-1:0] fast_lcnt,
  input  logic             capture,
  output logic [CNT_W-1:0] sel_h,
  output logic [CNT_W-1:0] sel_l,
  output logic [CNT_W-1:0] lat_h,
  output logic [CNT_W-1:0] lat_l
);
  localparam int NPAIR = 2;
  localparam logic [CNT_W-1:0] HMIN_V = CNT_W'(H_MIN);
  localparam logic [CNT_W-1:0] LMIN_V = CNT_W'(L_MIN);

  logic [CNT_W-1:0] raw_h [NPAIR];
  logic [CNT_W-1:0] raw_l [NPAIR];
  logic [CNT_W-1:0] clp_h [NPAIR];
  logic [CNT_W-1:0] clp_l [NPAIR];

  assign raw_h[0] = std_hcnt;
  assign raw_l[0] = std_lcnt;
  assign raw_h[1] = fast_hcnt;
  assign raw_l[1] = fast_lcnt;

  // clamp every pair to its minimum
  for (genvar g = 0; g < NPAIR; g++) begin : g_clamp
    assign clp_h[g] = (raw_h[g] < HMIN_V) ? HMIN_V : raw_h[g];
    assign clp_l[g] = (raw_l[g] < LMIN_V) ? LMIN_V : raw_l[g];
  end

  assign sel_h = clp_h[speed_sel];
  assign sel_l = clp_l[speed_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_h <= HMIN_V;
      lat_l <= LMIN_V;
    end else if (capture) begin
      lat_h <= sel_h;
      lat_l <= sel_l;
    end
  end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int PH_W = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [PH_W-1:0] ld_val,
  input  logic            dec,
  output logic            zero
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (ld)       cnt_q <= ld_val;
    else if (dec)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PH_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_req,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] sel_h,
  input  logic [CNT_W-1:0] lat_h,
  input  logic [CNT_W-1:0] lat_l,
  input  logic             zero,
  output logic             capture,
  output logic             ld,
  output logic [PH_W-1:0]  ld_val,
  output logic             dec,
  output logic             scl_pull_low,
  output logic             phase_hold,
  output logic             phase_low,
  output logic             phase_high,
  output logic             mst_active,
  output logic             bus_active
);
  localparam logic [PH_W-1:0] HOLD_ADD = PH_W'(HOLD_OVH - 1);
  localparam logic [PH_W-1:0] LOW_ADD  = PH_W'(LOW_OVH - 1);
  localparam logic [PH_W-1:0] HIGH_ADD = PH_W'(HIGH_OVH - 1);

  phase_e st_q, st_nxt;

  always_comb begin
    st_nxt  = st_q;
    capture = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    dec     = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (en && start_req) begin
          st_nxt  = PH_HOLD;
          capture = 1'b1;
          ld      = 1'b1;
          ld_val  = {1'b0, sel_h} + HOLD_ADD;
        end
      end
      PH_HOLD: begin
        if (zero) begin
          st_nxt = PH_LOW;
          ld     = 1'b1;
          ld_val = {1'b0, lat_l} + LOW_ADD;
        end else begin
          dec = 1'b1;
        end
      end
      PH_LOW: begin
        if (zero) begin
          if (en) begin
            st_nxt = PH_HIGH;
            ld     = 1'b1;
            ld_val = {1'b0, lat_h} + HIGH_ADD;
          end else begin
            st_nxt = PH_IDLE;
          end
        end else begin
          dec = 1'b1;
        end
      end
      PH_HIGH: begin
        // counting pauses while a target holds the line low
        if (scl_in) begin
          if (zero) begin
            st_nxt = PH_LOW;
            ld     = 1'b1;
            ld_val = {1'b0, lat_l} + LOW_ADD;
          end else begin
            dec = 1'b1;
          end
        end
      end
      default: st_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= PH_IDLE;
      scl_pull_low <= 1'b0;
      phase_hold   <= 1'b0;
      phase_low    <= 1'b0;
      phase_high   <= 1'b0;
      mst_active   <= 1'b0;
      bus_active   <= 1'b0;
    end else begin
      st_q         <= st_nxt;
      scl_pull_low <= (st_nxt == PH_LOW);
      phase_hold   <= (st_nxt == PH_HOLD);
      phase_low    <= (st_nxt == PH_LOW);
      phase_high   <= (st_nxt == PH_HIGH);
      mst_active   <= (st_nxt != PH_IDLE);
      bus_active   <= (st_nxt != PH_IDLE) || !scl_in;
    end
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W = 16,
  parameter int H_MIN = 6,
  parameter int L_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             speed_sel,
  input  logic [CNT_W-1:0] std_hcnt,
  input  logic [CNT_W-1:0] std_lcnt,
  input  logic [CNT_W-1:0] fast_hcnt,
  input  logic [CNT_W-1:0] fast_lcnt,
  input  logic             start_req,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             phase_hold,
  output logic             phase_low,
  output logic             phase_high,
  output logic             mst_active,
  output logic             bus_active
);
  localparam int PH_W = CNT_W + 1;

  logic [CNT_W-1:0] sel_h, sel_l, lat_h, lat_l;
  logic             capture, ld, dec, zero;
  logic [PH_W-1:0]  ld_val;
  logic             sel_l_unused;

  assign sel_l_unused = ^sel_l;

  scl_cnt_sel #(.CNT_W(CNT_W), .H_MIN(H_MIN), .L_MIN(L_MIN)) u_sel (
    .clk(clk), .rst(rst), .speed_sel(speed_sel),
    .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
    .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
    .capture(capture),
    .sel_h(sel_h), .sel_l(sel_l), .lat_h(lat_h), .lat_l(lat_l)
  );

  scl_phase_cnt #(.PH_W(PH_W)) u_cnt (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val), .dec(dec), .zero(zero)
  );

  scl_phase_fsm #(.CNT_W(CNT_W), .PH_W(PH_W)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .start_req(start_req), .scl_in(scl_in),
    .sel_h(sel_h), .lat_h(lat_h), .lat_l(lat_l), .zero(zero),
    .capture(capture), .ld(ld), .ld_val(ld_val), .dec(dec),
    .scl_pull_low(scl_pull_low), .phase_hold(phase_hold),
    .phase_low(phase_low), .phase_high(phase_high),
    .mst_active(mst_active), .bus_active(bus_active)
  );
endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk #(
  parameter int H_MIN = 6,
  parameter int L_MIN = 8
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_in,
  input logic scl_pull_low,
  input logic phase_hold,
  input logic phase_low,
  input logic phase_high,
  input logic mst_active,
  input logic bus_active
);
  int unsigned hold_run, low_run, high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_run <= 0;
      low_run  <= 0;
      high_run <= 0;
    end else begin
      hold_run <= phase_hold ? hold_run + 1 : 0;
      low_run  <= phase_low  ? low_run  + 1 : 0;
      high_run <= phase_high ? high_run + 1 : 0;
    end
  end

  p_onehot_phase_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phase_hold, phase_low, phase_high}));

  p_active_flag_r8: assert property (@(posedge clk) disable iff (rst)
    mst_active == (phase_hold || phase_low || phase_high));

  p_bus_cover_r9: assert property (@(posedge clk) disable iff (rst)
    mst_active |-> bus_active);

  p_hold_released_r4: assert property (@(posedge clk) disable iff (rst)
    phase_hold |-> !scl_pull_low);

  p_hold_to_low_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_hold) |-> phase_low);

  p_low_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_low) |-> (phase_high || !mst_active));

  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_high && !scl_in) |=> phase_high);

  p_idle_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    (!en && !mst_active) |=> !mst_active);

  p_low_min_r5: assert property (@(posedge clk) disable iff (rst)
    (!phase_low && low_run != 0) |-> low_run >= L_MIN + 1);

  p_high_min_r3: assert property (@(posedge clk) disable iff (rst)
    (!phase_high && high_run != 0) |-> high_run >= H_MIN + 8);

  p_hold_min_r4: assert property (@(posedge clk) disable iff (rst)
    (!phase_hold && hold_run != 0) |-> hold_run >= H_MIN + 3);
endmodule

bind scl_period_gen scl_gen_chk #(.H_MIN(H_MIN), .L_MIN(L_MIN)) u_chk (
  .clk(clk), .rst(rst), .en(en), .scl_in(scl_in),
  .scl_pull_low(scl_pull_low), .phase_hold(phase_hold),
  .phase_low(phase_low), .phase_high(phase_high),
  .mst_active(mst_active), .bus_active(bus_active)
);

// File: tb/sim_scl_period_gen.sv
`timescale 1ns/1ps
module sim_scl_period_gen;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic speed_sel = 1'b0;
  logic [CNT_W-1:0] std_hcnt = '0, std_lcnt = '0, fast_hcnt = '0, fast_lcnt = '0;
  logic start_req = 1'b0;
  logic stretch = 1'b0;
  logic scl_in;
  logic scl_pull_low, phase_hold, phase_low, phase_high, mst_active, bus_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign scl_in = !scl_pull_low && !stretch;

  scl_period_gen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .speed_sel(speed_sel),
    .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
    .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
    .start_req(start_req), .scl_in(scl_in),
    .scl_pull_low(scl_pull_low), .phase_hold(phase_hold),
    .phase_low(phase_low), .phase_high(phase_high),
    .mst_active(mst_active), .bus_active(bus_active)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int emax(input int a, input int m);
    return (a < m) ? m : a;
  endfunction

  // count consecutive negedges on which the selected flag is high
  task automatic span(input int which, output int n);
    n = 0;
    while (n < 4000 && ((which == 0 && phase_hold) || (which == 1 && phase_low) ||
                        (which == 2 && phase_high))) begin
      if (which == 1) check("R2 pull low during low phase", int'(scl_pull_low), 1);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic kick(input bit spd, input int h, input int l);
    en = 1'b0;
    speed_sel = spd;
    if (spd) begin
      fast_hcnt = CNT_W'(h); fast_lcnt = CNT_W'(l);
      std_hcnt  = CNT_W'(h + 20); std_lcnt = CNT_W'(l + 30);
    end else begin
      std_hcnt  = CNT_W'(h); std_lcnt = CNT_W'(l);
      fast_hcnt = CNT_W'(h + 20); fast_lcnt = CNT_W'(l + 30);
    end
    @(negedge clk);
    en = 1'b1;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    // R10: scramble the count inputs once the start is accepted
    std_hcnt = '0; std_lcnt = '0; fast_hcnt = '1; fast_lcnt = '1;
    speed_sel = ~spd;
  endtask

  task automatic run_case(input bit spd, input int h, input int l);
    int n;
    int eh = emax(h, 6);
    int el = emax(l, 8);
    kick(spd, h, l);
    check("R4 hold flag set", int'(phase_hold), 1);
    check("R4 line released in hold", int'(scl_pull_low), 0);
    span(0, n);
    check("R1 R4 R5 R10 hold length", n, eh + 3);
    check("R4 hold followed by low", int'(phase_low), 1);
    span(1, n);
    check("R1 R2 R5 R10 low length", n, el + 1);
    check("R7 high follows low while enabled", int'(phase_high), 1);
    check("R9 bus active while running", int'(bus_active), 1);
    span(2, n);
    check("R1 R3 R5 R10 high length", n, eh + 8);
    check("R8 active during second low", int'(mst_active), 1);
    en = 1'b0;
    span(1, n);
    check("R7 disabled low completes", n, el + 1);
    check("R7 idle after disable", int'(mst_active), 0);
    check("R7 line released after disable", int'(scl_pull_low), 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset pull", int'(scl_pull_low), 0);
    check("R12 reset phases", int'({phase_hold, phase_low, phase_high}), 0);
    check("R12 reset active", int'({mst_active, bus_active}), 0);

    // R11: start while disabled is ignored
    start_req = 1'b1;
    repeat (4) @(negedge clk);
    start_req = 1'b0;
    check("R11 no start while disabled", int'(mst_active), 0);
    check("R11 line untouched", int'(scl_pull_low), 0);

    // R9: external low on an idle bus
    stretch = 1'b1;
    @(negedge clk);
    check("R9 bus active from line", int'(bus_active), 1);
    check("R9 master stays idle", int'(mst_active), 0);
    stretch = 1'b0;
    @(negedge clk);
    check("R9 bus idle again", int'(bus_active), 0);

    // sweep both speeds, counts below, at and above minimum
    for (int s = 0; s < 2; s++)
      for (int h = 3; h <= 9; h++)
        for (int l = 5; l <= 11; l++)
          run_case(s[0], h, l);

    // R6: clock stretching by a target
    for (int k = 1; k <= 4; k++) begin
      kick(1'b0, 7, 9);
      span(0, n);
      stretch = 1'b1;
      span(1, n);
      n = 0;
      while (phase_high && n < 4000) begin
        n++;
        if (n == k + 1) stretch = 1'b0;
        @(negedge clk);
      end
      stretch = 1'b0;
      check("R6 stretched high length", n, 7 + 8 + k);
      en = 1'b0;
      span(1, n);
      check("R7 idle after stretched run", int'(mst_active), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule